// File: doc/BRIEF.md
# Register-Bank CRC-16 Checker

This block produces a 16-bit integrity signature over a fixed window of configuration registers. Software writes a trigger bit. The block then walks the window in ascending address order through a simple one-cycle-latency read port. For each word it clears the reserved bit positions and streams the result, most significant bit first, through a 16-stage serial LFSR. The register file and the per-address reserved-bit mask sit outside the block and are supplied to it through its ports.

The trigger bit belongs to the block. It reads back as 1 for the whole run and clears by itself when the run ends. Inside the configuration word the trigger position always enters the CRC as 1, whatever the register file returns there. When the run ends, the signature is committed to a result register in one cycle and a sticky done flag is set. Software clears that flag by writing 1 to it. An interrupt output follows the flag only while its enable is 1.

Top module: `crc_regbank_checker`

## Requirements
- R1: The signature uses generator 0x1021, a start value of 0xFFFF, no bit reflection of input or output and a final XOR of 0x0000. Each word is shifted in MSB first, one bit per clock.
- R2: Reads cover addresses 0x1A up to and including 0x24, one read per address, in ascending order. `rd_en` is never high for an address outside that window.
- R3: A bit that is 1 in `rsvd_mask`, which returns together with `rd_data`, enters the CRC as 0. Changing reserved bits in the register file leaves the result unchanged.
- R4: In the word at address 0x1A, bit 7 (the trigger position) enters the CRC as 1, whatever value the register file returns for that bit.
- R5: A `trig_set` pulse while idle sets `trig` and `busy` on the following clock edge.
- R6: The run takes 18 cycles per register (one read cycle, one load cycle, 16 shift cycles) plus one commit cycle. `crc_result` changes 199 edges after the edge that accepted the trigger, and holds its old value until then.
- R7: At commit, `done_stat` becomes 1 and `trig` becomes 0. `done_stat` stays 1 until a `stat_clr` pulse. If commit and `stat_clr` fall in the same cycle, the flag is set.
- R8: `irq` equals `done_stat` while `irq_en` is 1, and is 0 while `irq_en` is 0.
- R9: A `trig_set` pulse while `busy` is 1 is ignored: the run neither restarts nor lengthens.
- R10: `busy` is 1 from the cycle after the trigger until the commit cycle, inclusive, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trig_set | input | 1 | Software write of 1 to the trigger bit |
| stat_clr | input | 1 | Software write-1-to-clear of the done flag |
| irq_en | input | 1 | Interrupt enable for the done flag |
| rd_en | output | 1 | Read request to the register file |
| rd_addr | output | 8 | Register address being read |
| rd_data | input | 16 | Read data, valid the cycle after `rd_en` |
| rsvd_mask | input | 16 | Reserved-bit mask for the returned word, valid with `rd_data` |
| trig | output | 1 | Trigger bit as software reads it |
| busy | output | 1 | Run in progress |
| crc_result | output | 16 | Last committed signature |
| done_stat | output | 1 | Sticky done status flag |
| irq | output | 1 | Gated done interrupt |

## Verification
Every result has a fixed due cycle, counted from the edge that accepts `trig_set`. `trig` and `busy` rise after that edge. The signature, the done flag and the falling `trig` and `busy` appear after edge 199. The bench drives inputs and samples outputs on falling edges. It counts exactly that many falling edges, and it also samples one edge early to confirm that the result register still holds its old value and `busy` is still high. `irq` is combinational from the flag and its enable, so it is checked in the same sample as a change of `irq_en`.

// File: rtl/crc_rb_pkg.sv
package crc_rb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_WAIT  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_DONE  = 3'd4
  } crc_state_e;
endpackage

// File: rtl/crc_rb_seq.sv
module crc_rb_seq
  import crc_rb_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned FIRST    = 8'h1A,
  parameter int unsigned LAST     = 8'h24,
  parameter int unsigned CFG_ADDR = 8'h1A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_set,
  output logic              start,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              load,
  output logic              shift,
  output logic              cfg_sel,
  output logic              commit,
  output logic              busy
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(FIRST);
  localparam logic [ADDR_W-1:0] A_LAST   = ADDR_W'(LAST);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(CFG_ADDR);

  crc_state_e        state_q, state_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;

  always_comb begin
    state_n = state_q;
    addr_n  = addr_q;
    cnt_n   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (trig_set) begin
        state_n = ST_FETCH;
        addr_n  = A_FIRST;
      end
      ST_FETCH: state_n = ST_WAIT;
      ST_WAIT: begin
        state_n = ST_SHIFT;
        cnt_n   = '0;
      end
      ST_SHIFT: begin
        cnt_n = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_LAST) begin
          if (addr_q == A_LAST) begin
            state_n = ST_DONE;
          end else begin
            state_n = ST_FETCH;
            addr_n  = addr_q + ADDR_W'(1);
          end
        end
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      addr_q  <= addr_n;
      cnt_q   <= cnt_n;
    end
  end

  assign start   = (state_q == ST_IDLE) && trig_set;
  assign rd_en   = (state_q == ST_FETCH);
  assign rd_addr = addr_q;
  assign load    = (state_q == ST_WAIT);
  assign shift   = (state_q == ST_SHIFT);
  assign cfg_sel = (addr_q == A_CFG);
  assign commit  = (state_q == ST_DONE);
  assign busy    = (state_q != ST_IDLE);

  // R2: reads stay inside the covered window
  p_rd_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr >= A_FIRST && rd_addr <= A_LAST));
  // R2: each new fetch after shifting moves exactly one address up
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && cnt_q == CNT_LAST && addr_q != A_LAST) |=> (rd_en && rd_addr == $past(addr_q) + ADDR_W'(1)));
  // R10: busy never drops before the commit cycle
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> busy);
  // R6: commit is followed by idle
  p_commit_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);
endmodule

// File: rtl/crc_rb_mask.sv
module crc_rb_mask #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned TRIG_BIT = 7
) (
  input  logic [DATA_W-1:0] raw,
  input  logic [DATA_W-1:0] rsvd,
  input  logic              cfg_sel,
  output logic [DATA_W-1:0] clean
);
  localparam logic [DATA_W-1:0] FORCE = DATA_W'(1) << TRIG_BIT;

  always_comb begin
    clean = raw & ~rsvd;
    if (cfg_sel) clean = clean | FORCE;
  end
endmodule

// File: rtl/crc_rb_lfsr.sv
module crc_rb_lfsr #(
  parameter int unsigned       CRC_W  = 16,
  parameter int unsigned       DATA_W = 16,
  parameter logic [CRC_W-1:0]  POLY   = 16'h1021,
  parameter logic [CRC_W-1:0]  SEED   = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] word,
  output logic [CRC_W-1:0]  crc
);
  logic [CRC_W-1:0]  crc_q, crc_n, crc_step;
  logic [DATA_W-1:0] word_q, word_n;
  logic              fb;

  assign fb = crc_q[CRC_W-1] ^ word_q[DATA_W-1];

  for (genvar i = 0; i < CRC_W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign crc_step[i] = POLY[i] & fb;
    end else begin : g_mid
      assign crc_step[i] = crc_q[i-1] ^ (POLY[i] & fb);
    end
  end

  always_comb begin
    crc_n  = crc_q;
    word_n = word_q;
    if (seed)  crc_n = SEED;
    if (shift) begin
      crc_n  = crc_step;
      word_n = {word_q[DATA_W-2:0], 1'b0};
    end
    if (load) word_n = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      word_q <= '0;
    end else begin
      crc_q  <= crc_n;
      word_q <= word_n;
    end
  end

  assign crc  = crc_q;
  assign word = word_q;

  // R1: every run starts from the seed
  p_seed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    seed |=> (crc == SEED));
  // R1: register is untouched when neither seeding nor shifting
  p_crc_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed && !shift) |=> $stable(crc));
endmodule

// File: rtl/crc_rb_status.sv
module crc_rb_status #(
  parameter int unsigned CRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             commit,
  input  logic             stat_clr,
  input  logic             irq_en,
  input  logic [CRC_W-1:0] crc,
  output logic             trig,
  output logic             done_stat,
  output logic             irq,
  output logic [CRC_W-1:0] result
);
  logic             trig_q, trig_n;
  logic             stat_q, stat_n;
  logic [CRC_W-1:0] res_q, res_n;

  always_comb begin
    trig_n = trig_q;
    if (start)       trig_n = 1'b1;
    else if (commit) trig_n = 1'b0;

    stat_n = stat_q;
    if (stat_clr) stat_n = 1'b0;
    if (commit)   stat_n = 1'b1;

    res_n = res_q;
    if (commit) res_n = crc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      stat_q <= 1'b0;
      res_q  <= '0;
    end else begin
      trig_q <= trig_n;
      stat_q <= stat_n;
      res_q  <= res_n;
    end
  end

  assign trig      = trig_q;
  assign done_stat = stat_q;
  assign irq       = stat_q & irq_en;
  assign result    = res_q;

  // R9: trigger bit is not disturbed until the run commits
  p_trig_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && !commit) |=> trig_q);
  // R7: commit sets the flag, even against a clear in the same cycle
  p_stat_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (stat_q && !trig_q));
  // R7: flag stays set without a clear
  p_stat_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !stat_clr) |=> stat_q);
endmodule

// File: rtl/crc_regbank_checker.sv
module crc_regbank_checker #(
  parameter int unsigned      ADDR_W   = 8,
  parameter int unsigned      DATA_W   = 16,
  parameter int unsigned      CRC_W    = 16,
  parameter int unsigned      FIRST    = 8'h1A,
  parameter int unsigned      LAST     = 8'h24,
  parameter int unsigned      CFG_ADDR = 8'h1A,
  parameter int unsigned      TRIG_BIT = 7,
  parameter logic [CRC_W-1:0] POLY     = 16'h1021,
  parameter logic [CRC_W-1:0] SEED     = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_set,
  input  logic              stat_clr,
  input  logic              irq_en,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] rsvd_mask,
  output logic              trig,
  output logic              busy,
  output logic [CRC_W-1:0]  crc_result,
  output logic              done_stat,
  output logic              irq
);
  localparam logic [DATA_W-1:0] FORCE_BIT = DATA_W'(1) << TRIG_BIT;

  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic              start, load, shift, cfg_sel, commit;
  logic [DATA_W-1:0] clean, word;
  logic [CRC_W-1:0]  crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  crc_rb_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIRST(FIRST), .LAST(LAST), .CFG_ADDR(CFG_ADDR)
  ) u_seq (
    .clk(clk), .rst_n(rst_i_n), .trig_set(trig_set), .start(start),
    .rd_en(rd_en), .rd_addr(rd_addr), .load(load), .shift(shift),
    .cfg_sel(cfg_sel), .commit(commit), .busy(busy)
  );

  crc_rb_mask #(.DATA_W(DATA_W), .TRIG_BIT(TRIG_BIT)) u_mask (
    .raw(rd_data), .rsvd(rsvd_mask), .cfg_sel(cfg_sel), .clean(clean)
  );

  crc_rb_lfsr #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_i_n), .seed(start), .load(load), .shift(shift),
    .din(clean), .word(word), .crc(crc)
  );

  crc_rb_status #(.CRC_W(CRC_W)) u_stat (
    .clk(clk), .rst_n(rst_i_n), .start(start), .commit(commit),
    .stat_clr(stat_clr), .irq_en(irq_en), .crc(crc),
    .trig(trig), .done_stat(done_stat), .irq(irq), .result(crc_result)
  );

  // R3: reserved positions of the returned word reach the shifter as zero
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    load |=> ((word & $past(rsvd_mask) & ~($past(cfg_sel) ? FORCE_BIT : '0)) == '0));
  // R4: trigger position of the configuration word enters as one
  p_trig_force_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (load && cfg_sel) |=> word[TRIG_BIT]);
  // R5: trigger and busy rise together
  p_busy_trig_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy |-> trig);
  // R6: result register only moves on commit
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    !commit |=> $stable(crc_result));
  // R8: no interrupt while disabled
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    !irq_en |-> !irq);
endmodule

// File: tb/tb_crc_regbank_checker.sv
module tb_crc_regbank_checker;
  localparam int CLK_NS  = 4;
  localparam int FIRST   = 8'h1A;
  localparam int LAST    = 8'h24;
  localparam int TBIT    = 7;
  localparam int RUN_CYC = 199;
  localparam int NVEC    = 6;
  // {pattern, irq_en}
  localparam logic [16:0] VEC [NVEC] = '{
    {16'h0000, 1'b1}, {16'hFFFF, 1'b0}, {16'hA5C3, 1'b1},
    {16'h1234, 1'b0}, {16'h8001, 1'b1}, {16'h7E18, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_set = 1'b0, stat_clr = 1'b0, irq_en = 1'b0;
  logic        rd_en, trig, busy, done_stat, irq;
  logic [7:0]  rd_addr;
  logic [15:0] rd_data, rsvd_mask, crc_result;
  logic [15:0] regs [0:63];
  int          n_chk = 0, n_err = 0;
  bit          ended = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  crc_regbank_checker dut (
    .clk(clk), .rst_n(rst_n), .trig_set(trig_set), .stat_clr(stat_clr),
    .irq_en(irq_en), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rsvd_mask(rsvd_mask), .trig(trig), .busy(busy), .crc_result(crc_result),
    .done_stat(done_stat), .irq(irq)
  );

  function automatic logic [15:0] mask_of(input int a);
    logic [15:0] m;
    m = 16'h8000 >> (a % 16);
    if (a % 2 == 1) m = m | 16'h0030;
    return m;
  endfunction

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data   <= regs[rd_addr[5:0]];
      rsvd_mask <= mask_of(int'(rd_addr));
    end
  end

  function automatic logic [15:0] expect_crc();
    logic [15:0] c, w;
    logic        f;
    c = 16'hFFFF;
    for (int a = FIRST; a <= LAST; a++) begin
      w = regs[a] & ~mask_of(a);
      if (a == FIRST) w[TBIT] = 1'b1;
      for (int b = 15; b >= 0; b--) begin
        f = c[15] ^ w[b];
        c = {c[14:0], 1'b0};
        if (f) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [15:0] pat);
    for (int a = 0; a < 64; a++) regs[a] = pat ^ 16'(a * 16'h0101) ^ 16'(a << 9);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // starts a run; returns at the negedge right after the accepting edge
  task automatic kick();
    trig_set = 1'b1;
    @(negedge clk);
    trig_set = 1'b0;
  endtask

  task automatic finish_run(input string tag, input logic [15:0] old_res,
                            input logic [15:0] exp_res, input logic en);
    chk({tag, " R5 trig"}, trig, 1);
    chk({tag, " R5 busy"}, busy, 1);
    tick(RUN_CYC - 1);
    chk({tag, " R10 busy before commit"}, busy, 1);
    chk({tag, " R6 result held"}, crc_result, old_res);
    tick(1);
    chk({tag, " R10 busy low"}, busy, 0);
    chk({tag, " R1 result"}, crc_result, exp_res);
    chk({tag, " R7 stat"}, done_stat, 1);
    chk({tag, " R7 trig cleared"}, trig, 0);
    chk({tag, " R8 irq"}, irq, en);
  endtask

  task automatic clear_stat();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!ended) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev, ref_a;
    fill(16'h0000);
    tick(3);
    // reset state
    chk("reset busy", busy, 0);
    chk("reset trig", trig, 0);
    chk("reset stat R7", done_stat, 0);
    chk("reset irq R8", irq, 0);
    chk("reset result", crc_result, 0);
    rst_n = 1'b1;
    tick(4);
    chk("R10 idle busy", busy, 0);

    prev = crc_result;
    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] e;
      fill(VEC[v][16:1]);
      irq_en = VEC[v][0];
      e = expect_crc();
      kick();
      finish_run($sformatf("vec%0d", v), prev, e, VEC[v][0]);
      prev = e;
      clear_stat();
      chk("R7 cleared by write", done_stat, 0);
      chk("R8 irq follows clear", irq, 0);
      tick(2);
    end

    // R3: changing reserved bits does not move the result
    fill(16'h3C96);
    ref_a = expect_crc();
    for (int a = FIRST; a <= LAST; a++) regs[a] = regs[a] ^ mask_of(a);
    irq_en = 1'b0;
    kick();
    finish_run("R3 rsvd flip", prev, ref_a, 1'b0);
    prev = ref_a;

    // R4: trigger position forced to one regardless of stored value
    regs[FIRST] = regs[FIRST] & ~(16'h1 << TBIT);
    clear_stat();
    kick();
    finish_run("R4 trig zero in file", prev, ref_a, 1'b0);
    regs[FIRST] = regs[FIRST] | (16'h1 << TBIT);
    clear_stat();
    kick();
    finish_run("R4 trig one in file", prev, ref_a, 1'b0);

    // R8: enabling later raises irq on the pending flag
    irq_en = 1'b1;
    #1;
    chk("R8 irq on enable", irq, 1);
    irq_en = 1'b0;
    #1;
    chk("R8 irq off disable", irq, 0);
    tick(1);

    // R9: trigger during a run is ignored
    clear_stat();
    fill(16'hBEEF);
    ref_a = expect_crc();
    kick();
    tick(50);
    trig_set = 1'b1;
    @(negedge clk);
    trig_set = 1'b0;
    tick(RUN_CYC - 52);
    chk("R9 busy before commit", busy, 1);
    tick(1);
    chk("R9 result on time", crc_result, ref_a);
    chk("R9 no restart busy", busy, 0);
    tick(1);
    chk("R9 still idle", busy, 0);

    // R7: commit coincident with clear keeps flag set
    kick();
    tick(RUN_CYC - 1);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    chk("R7 set wins over clear", done_stat, 1);

    // R2: read addresses ascending through the window
    begin
      int last_a = -1;
      int cnt = 0;
      bit order_ok = 1'b1;
      trig_set = 1'b1;
      for (int i = 0; i < RUN_CYC + 2; i++) begin
        @(negedge clk);
        trig_set = 1'b0;
        if (rd_en) begin
          if (int'(rd_addr) != (cnt == 0 ? FIRST : last_a + 1)) order_ok = 1'b0;
          last_a = int'(rd_addr);
          cnt++;
        end
      end
      chk("R2 read order", order_ok, 1);
      chk("R2 read count", cnt, LAST - FIRST + 1);
    end

    ended = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule